// File: doc/BRIEF.md
# Temperature-Indexed Supply Step Controller

This block picks a supply regulator code from the die temperature and the active frequency state, then walks the regulator toward that code one step at a time. It is meant for low-voltage operation, where a hotter die switches faster. A programmable code table is therefore normally filled so that warmer temperature bands get equal or lower codes. One regulator code step stands for 6.25 mV. One temperature band maps to one code, because the regulator output is quantised.

The temperature reading is reduced to a band index by comparing it against a set of programmable, ascending thresholds. The table is indexed by frequency state and band. The resulting entry is bounded by a programmable floor and ceiling. Once per update period (`TICK_CYCLES` clocks, about one millisecond at the default), the output code moves one step toward the bounded target, and `vout_stb` marks every change.

A frequency-state change is a valid/ready transfer. The requester raises `freq_req_valid` with `freq_req_state` and holds both unchanged until `freq_req_ready` is high at a rising clock edge. While a request waits, the target follows the requested state. The controller accepts the request only once the output code has reached that target, so the voltage is raised before the faster clock is allowed. A request that needs a lower code is accepted at once, and the code then walks down afterwards. Configuration is a plain single-cycle write port.

Top module: `tvs_ctrl`

## Requirements
- R1: After reset, `vout_code` is `RESET_CODE` (default 112, 0.7 V), `vout_stb` is 0, `fstate_active` is 0, and `freq_req_ready` is 0 while no request is valid.
- R2: The band is the number of thresholds that are less than or equal to `temp_code`. A reading below threshold 0 is band 0, a reading equal to a threshold falls in the higher band, and a reading at or above the top threshold uses the last band, `NUM_BANDS-1`.
- R3: The raw target is the table entry at index `state*NUM_BANDS + band`. Here `state` is the requested state while `freq_req_valid` is high, and `fstate_active` otherwise.
- R4: Update ticks occur every `TICK_CYCLES` clocks. On a tick with a valid reading, `vout_code` moves exactly one code toward the bounded target. It never changes between ticks. `vout_stb` is high for exactly the one cycle after each change.
- R5: The bounded target is max(min(entry, ceiling), floor). The floor wins if the two bounds cross. A downward step never lands below the floor.
- R6: On a tick where `temp_valid` is 0, `vout_code` holds and the stored band is not updated.
- R7: `freq_req_ready` is high only while a request is valid and `vout_code` is at or above the bounded target of the requested state. After a transfer, `fstate_active` equals the transferred state.
- R8: Config writes are steered by `cfg_kind`: 0 writes a table entry at `cfg_addr`, 1 writes threshold `cfg_addr`, 2 writes the floor, and 3 writes the ceiling. Entry or threshold writes with an out-of-range address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Config write enable |
| cfg_kind | input | 2 | Write target select (entry, threshold, floor, ceiling) |
| cfg_addr | input | ADDR_W | Entry or threshold index |
| cfg_data | input | DATA_W | Write data |
| temp_code | input | TEMP_W | Die temperature reading |
| temp_valid | input | 1 | Temperature reading is trustworthy |
| freq_req_valid | input | 1 | Frequency change request valid |
| freq_req_state | input | FSTATE_W | Requested frequency state |
| freq_req_ready | output | 1 | Request accepted this cycle |
| fstate_active | output | FSTATE_W | Frequency state currently in force |
| vout_code | output | CODE_W | Regulator code request |
| vout_stb | output | 1 | One-cycle strobe on each code change |

## Verification
A corrupted threshold or table entry shows up as the output code settling one band's worth away from the expected code, within a few update periods of the reading crossing that band. A broken tick counter shows up as the gap between two strobes differing from `TICK_CYCLES`, or as a jump of more than one code. A wrong handshake shows up at the first frequency request, either as acceptance while the code is still below the new target or as a stale `fstate_active` on the next cycle.

// File: rtl/tvs_pkg.sv
package tvs_pkg;
  typedef enum logic [1:0] {
    CFG_ENTRY  = 2'd0,
    CFG_THRESH = 2'd1,
    CFG_FLOOR  = 2'd2,
    CFG_CEIL   = 2'd3
  } cfg_kind_e;
endpackage

// File: rtl/tvs_band_quantizer.sv
module tvs_band_quantizer #(
  parameter int TEMP_W    = 8,
  parameter int NUM_BANDS = 6,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 8,
  parameter int THR_STEP  = 40,
  localparam int NUM_THR  = NUM_BANDS - 1,
  localparam int BAND_W   = $clog2(NUM_BANDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_kind,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic              update_en,
  output logic [BAND_W-1:0] band_sel
);
  import tvs_pkg::*;

  logic [TEMP_W-1:0] thr_q [NUM_THR];
  logic [BAND_W-1:0] band_now;
  logic [BAND_W-1:0] band_q;

  // Ascending thresholds, one register each
  for (genvar i = 0; i < NUM_THR; i++) begin : g_thr
    always_ff @(posedge clk) begin
      if (!rst_n)
        thr_q[i] <= TEMP_W'((i + 1) * THR_STEP);
      else if (cfg_we && cfg_kind_e'(cfg_kind) == CFG_THRESH &&
               cfg_addr == ADDR_W'(i))
        thr_q[i] <= cfg_data[TEMP_W-1:0];
    end
  end

  // Band = count of thresholds at or below the reading
  always_comb begin
    band_now = '0;
    for (int i = 0; i < NUM_THR; i++)
      if (temp_code >= thr_q[i]) band_now = band_now + BAND_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         band_q <= '0;
    else if (update_en) band_q <= band_now;
  end

  assign band_sel = update_en ? band_now : band_q;

  // R2
  band_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(band_sel) < NUM_BANDS);

endmodule

// File: rtl/tvs_code_table.sv
module tvs_code_table #(
  parameter int NUM_ENTRIES = 24,
  parameter int ADDR_W      = 5,
  parameter int CODE_W      = 8,
  parameter int DATA_W      = 8,
  parameter int RESET_CODE  = 112
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_kind,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic [ADDR_W-1:0] rd_idx,
  output logic [CODE_W-1:0] rd_code
);
  import tvs_pkg::*;

  logic [CODE_W-1:0] ent_q [NUM_ENTRIES];

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        ent_q[e] <= CODE_W'(RESET_CODE);
      else if (cfg_we && cfg_kind_e'(cfg_kind) == CFG_ENTRY &&
               cfg_addr == ADDR_W'(e))
        ent_q[e] <= cfg_data[CODE_W-1:0];
    end
  end

  always_comb begin
    rd_code = CODE_W'(RESET_CODE);
    for (int e = 0; e < NUM_ENTRIES; e++)
      if (rd_idx == ADDR_W'(e)) rd_code = ent_q[e];
  end

endmodule

// File: rtl/tvs_slew_stepper.sv
module tvs_slew_stepper #(
  parameter int CODE_W      = 8,
  parameter int DATA_W      = 8,
  parameter int TICK_CYCLES = 100000,
  parameter int RESET_CODE  = 112,
  localparam int CNT_W      = $clog2(TICK_CYCLES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_kind,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic [CODE_W-1:0] entry_code,
  input  logic              temp_valid,
  output logic              tick,
  output logic [CODE_W-1:0] eff_target,
  output logic [CODE_W-1:0] vout_code,
  output logic              vout_stb
);
  import tvs_pkg::*;

  logic [CNT_W-1:0]  cnt_q;
  logic [CODE_W-1:0] floor_q, ceil_q, lim, vout_q;
  logic              stb_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + CNT_W'(1);
  end
  assign tick = (cnt_q == CNT_W'(TICK_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      floor_q <= '0;
      ceil_q  <= '1;
    end else if (cfg_we) begin
      if (cfg_kind_e'(cfg_kind) == CFG_FLOOR) floor_q <= cfg_data[CODE_W-1:0];
      if (cfg_kind_e'(cfg_kind) == CFG_CEIL)  ceil_q  <= cfg_data[CODE_W-1:0];
    end
  end

  // Ceiling first, then floor: the floor has the last word
  assign lim        = (entry_code > ceil_q) ? ceil_q : entry_code;
  assign eff_target = (lim < floor_q) ? floor_q : lim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vout_q <= CODE_W'(RESET_CODE);
      stb_q  <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (tick && temp_valid) begin
        if (vout_q < eff_target) begin
          vout_q <= vout_q + CODE_W'(1);
          stb_q  <= 1'b1;
        end else if (vout_q > eff_target) begin
          vout_q <= vout_q - CODE_W'(1);
          stb_q  <= 1'b1;
        end
      end
    end
  end

  assign vout_code = vout_q;
  assign vout_stb  = stb_q;

  // R4
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vout_q != $past(vout_q)) |->
      ((vout_q == $past(vout_q) + CODE_W'(1)) ||
       (vout_q + CODE_W'(1) == $past(vout_q))));
  // R4
  change_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vout_q != $past(vout_q)) |-> $past(tick));
  // R6
  hold_on_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tick && !temp_valid) |-> (vout_q == $past(vout_q)));
  // R5
  floor_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vout_q < $past(vout_q)) |-> (vout_q >= $past(floor_q)));

endmodule

// File: rtl/tvs_ctrl.sv
module tvs_ctrl #(
  parameter int TEMP_W      = 8,
  parameter int CODE_W      = 8,
  parameter int NUM_FSTATES = 4,
  parameter int NUM_BANDS   = 6,
  parameter int TICK_CYCLES = 100000,
  parameter int RESET_CODE  = 112,
  parameter int THR_STEP    = 40,
  localparam int NUM_ENTRIES = NUM_FSTATES * NUM_BANDS,
  localparam int ADDR_W     = $clog2(NUM_ENTRIES),
  localparam int FSTATE_W   = $clog2(NUM_FSTATES),
  localparam int BAND_W     = $clog2(NUM_BANDS),
  localparam int DATA_W     = (CODE_W > TEMP_W) ? CODE_W : TEMP_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_kind,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [DATA_W-1:0]   cfg_data,
  input  logic [TEMP_W-1:0]   temp_code,
  input  logic                temp_valid,
  input  logic                freq_req_valid,
  input  logic [FSTATE_W-1:0] freq_req_state,
  output logic                freq_req_ready,
  output logic [FSTATE_W-1:0] fstate_active,
  output logic [CODE_W-1:0]   vout_code,
  output logic                vout_stb
);

  logic [FSTATE_W-1:0] fstate_q, state_sel;
  logic [BAND_W-1:0]   band_sel;
  logic [ADDR_W-1:0]   rd_idx;
  logic [CODE_W-1:0]   entry_code, eff_target, vout_int;
  logic                tick;

  tvs_band_quantizer #(
    .TEMP_W(TEMP_W), .NUM_BANDS(NUM_BANDS), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .THR_STEP(THR_STEP)
  ) quant_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .temp_code(temp_code),
    .update_en(tick && temp_valid), .band_sel(band_sel)
  );

  // A pending request steers the lookup so the code rises first
  assign state_sel = freq_req_valid ? freq_req_state : fstate_q;
  assign rd_idx    = ADDR_W'(state_sel) * ADDR_W'(NUM_BANDS) + ADDR_W'(band_sel);

  tvs_code_table #(
    .NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W), .CODE_W(CODE_W),
    .DATA_W(DATA_W), .RESET_CODE(RESET_CODE)
  ) table_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .rd_idx(rd_idx),
    .rd_code(entry_code)
  );

  tvs_slew_stepper #(
    .CODE_W(CODE_W), .DATA_W(DATA_W), .TICK_CYCLES(TICK_CYCLES),
    .RESET_CODE(RESET_CODE)
  ) step_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_data(cfg_data), .entry_code(entry_code), .temp_valid(temp_valid),
    .tick(tick), .eff_target(eff_target), .vout_code(vout_int),
    .vout_stb(vout_stb)
  );

  assign freq_req_ready = freq_req_valid && (vout_int >= eff_target);

  always_ff @(posedge clk) begin
    if (!rst_n)                               fstate_q <= '0;
    else if (freq_req_valid && freq_req_ready) fstate_q <= freq_req_state;
  end

  assign fstate_active = fstate_q;
  assign vout_code     = vout_int;

  // R7
  fstate_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_req_valid && freq_req_ready) |=> (fstate_q == $past(freq_req_state)));

endmodule

// File: tb/tvs_ctrl_tb_top.sv
module tvs_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICK = 8;
  localparam int SETTLE = TICK * 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_kind = 2'd0;
  logic [4:0] cfg_addr = '0;
  logic [7:0] cfg_data = '0;
  logic [7:0] temp_code = '0;
  logic       temp_valid = 1'b0;
  logic       freq_req_valid = 1'b0;
  logic [1:0] freq_req_state = '0;
  logic       freq_req_ready;
  logic [1:0] fstate_active;
  logic [7:0] vout_code;
  logic       vout_stb;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tvs_ctrl #(.TICK_CYCLES(TICK)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .temp_code(temp_code),
    .temp_valid(temp_valid), .freq_req_valid(freq_req_valid),
    .freq_req_state(freq_req_state), .freq_req_ready(freq_req_ready),
    .fstate_active(fstate_active), .vout_code(vout_code), .vout_stb(vout_stb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int kind, input int addr, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = 2'(kind); cfg_addr = 5'(addr); cfg_data = 8'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic set_temp(input int t);
    @(negedge clk);
    temp_code = 8'(t); temp_valid = 1'b1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(vout_code == 8'd112, "R1 code", vout_code, 112);
    chk(vout_stb == 1'b0, "R1 stb", vout_stb, 0);
    chk(fstate_active == 2'd0, "R1 fstate", fstate_active, 0);
    chk(freq_req_ready == 1'b0, "R1 ready", freq_req_ready, 0);
  endtask

  task automatic t_program();
    for (int i = 0; i < 5; i++) cfg_write(1, i, 20 * (i + 1));  // R8 thresholds
    for (int b = 0; b < 6; b++) cfg_write(0, b, 112 - 2 * b);
    for (int b = 0; b < 6; b++) cfg_write(0, 6 + b, 120 - b);
  endtask

  task automatic t_bands();
    set_temp(50);  settle(); chk(vout_code == 8'd108, "R2/R3 mid band", vout_code, 108);
    set_temp(100); settle(); chk(vout_code == 8'd102, "R2 at top thr", vout_code, 102);
    set_temp(255); settle(); chk(vout_code == 8'd102, "R2 above top", vout_code, 102);
    set_temp(19);  settle(); chk(vout_code == 8'd112, "R2 below first", vout_code, 112);
    set_temp(20);  settle(); chk(vout_code == 8'd110, "R2 equal first", vout_code, 110);
  endtask

  task automatic t_step_rate();
    int n;
    set_temp(90);  // band 4 -> 104
    n = 0;
    do begin @(negedge clk); n++; end while (!vout_stb && n < 4 * TICK);
    chk(vout_code == 8'd109, "R4 first step", vout_code, 109);
    @(negedge clk);
    chk(vout_stb == 1'b0, "R4 stb one cycle", vout_stb, 0);
    n = 1;
    while (!vout_stb && n < 4 * TICK) begin @(negedge clk); n++; end
    chk(n == TICK, "R4 tick period", n, TICK);
    chk(vout_code == 8'd108, "R4 second step", vout_code, 108);
    settle();
    chk(vout_code == 8'd104, "R4 settled", vout_code, 104);
  endtask

  task automatic t_invalid();
    bit saw = 1'b0;
    @(negedge clk);
    temp_valid = 1'b0; temp_code = 8'd0;
    for (int i = 0; i < 5 * TICK; i++) begin
      @(negedge clk);
      if (vout_stb) saw = 1'b1;
    end
    chk(vout_code == 8'd104, "R6 code held", vout_code, 104);
    chk(saw == 1'b0, "R6 no strobe", int'(saw), 0);
    set_temp(90); settle();
    chk(vout_code == 8'd104, "R6 band kept", vout_code, 104);
  endtask

  task automatic t_clamp();
    cfg_write(2, 0, 106); settle();
    chk(vout_code == 8'd106, "R5 floor", vout_code, 106);
    cfg_write(2, 0, 0); cfg_write(3, 0, 108); set_temp(10); settle();
    chk(vout_code == 8'd108, "R5 ceiling", vout_code, 108);
    cfg_write(2, 0, 110); set_temp(90); settle();
    chk(vout_code == 8'd110, "R5 floor wins", vout_code, 110);
    cfg_write(2, 0, 0); cfg_write(3, 0, 255); settle();
    chk(vout_code == 8'd104, "R5 released", vout_code, 104);
  endtask

  task automatic t_freq();
    bit got = 1'b0;
    int code_at = 0;
    @(negedge clk);
    freq_req_valid = 1'b1; freq_req_state = 2'd1;
    #1;
    chk(freq_req_ready == 1'b0, "R7 not ready low code", freq_req_ready, 0);
    for (int i = 0; i < 30 * TICK && !got; i++) begin
      if (freq_req_ready) begin got = 1'b1; code_at = vout_code; end
      else @(negedge clk);
    end
    @(negedge clk);
    freq_req_valid = 1'b0;
    chk(got && code_at == 116, "R7 raise before ack", code_at, 116);
    chk(fstate_active == 2'd1, "R7 state taken", fstate_active, 1);
    freq_req_valid = 1'b1; freq_req_state = 2'd0;
    #1;
    chk(freq_req_ready == 1'b1, "R7 lower ack at once", freq_req_ready, 1);
    @(negedge clk);
    freq_req_valid = 1'b0;
    chk(fstate_active == 2'd0, "R7 back to state 0", fstate_active, 0);
    settle();
    chk(vout_code == 8'd104, "R7 walk down", vout_code, 104);
  endtask

  task automatic t_cfg_decode();
    cfg_write(0, 31, 0);
    cfg_write(1, 5, 0);
    settle();
    chk(vout_code == 8'd104, "R8 out of range ignored", vout_code, 104);
    cfg_write(1, 3, 95); settle();
    chk(vout_code == 8'd106, "R8 threshold write", vout_code, 106);
    cfg_write(1, 3, 80); settle();
    chk(vout_code == 8'd104, "R8 threshold restore", vout_code, 104);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_program();
    t_bands();
    t_step_rate();
    t_invalid();
    t_clamp();
    t_freq();
    t_cfg_decode();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule